// File: doc/BRIEF.md
# Multi-Mode Counter/Timer Channel

This block is one 16-bit timer channel. A programmable divider sits in front of the counter, and a small write port configures it. Five modes share one counter.

- **Pulse mode** gives a one-shot output.
- **Waveform mode** gives a free-running square wave.
- **Event mode** counts edges on an event pin.
- **Capture mode** latches the running count when a trigger edge arrives.
- **Watchdog mode** raises a reset output unless software keeps servicing it.

The counter counts up or down. A one-cycle terminal-count pulse is sent on to interrupt logic.

Software drives the write port, which has three registers:

| Address | Register | Fields |
|---|---|---|
| 0 | Control | bits [2:0] mode, bit 3 direction, bit 4 run |
| 1 | Reload | 16-bit reload value |
| 2 | Divider | ratio, bits [8:0] |

Mode codes are 0 pulse, 1 waveform, 2 event, 3 capture and 4 watchdog. Codes 5 to 7 never advance the counter. Direction is 1 for up and 0 for down. Address 3 is not decoded.

A level gate input allows counting only while it is high. The trigger and event pins are asynchronous. Each passes through a two-flop synchronizer followed by an edge detector. The channel reacts to a pin's rising edge on the third clock edge after the pin is first sampled high.

Top module: `mmct_channel`

## Requirements
- R1: The divider ratio is clamped to 4 when the written value is below 4, and to 280 when it is above 280. In the timed modes, one count step is allowed every ratio cycles while running. The divider restarts from zero on a control write or a watchdog service.
- R2: A step at the terminal value loads the start value; every other step moves the count by one in the selected direction.
  - Counting up, the start value is 0 and the terminal value is reached when the count is at or above reload.
  - Counting down, the start value is reload and the terminal value is zero.
  - One period is therefore reload+1 steps.
- R3: `tc_pulse` is high for exactly one cycle, in the cycle after each step taken at the terminal value.
- R4: While `gate_en` is low or the run bit is 0, the count does not move.
- R5: In waveform mode, `wave_out` toggles at every terminal step and the counter reloads automatically.
- R6: In pulse mode, the count holds while idle. A trigger edge while running loads the start value and drives `wave_out` high. The terminal step drives `wave_out` low and the channel returns to idle.
- R7: In event mode, the count advances once per rising edge of `evt_in` (subject to R4), and the divider has no effect.
- R8: In capture mode while running, a trigger edge copies the present count into `cap_value`, and the counter keeps running.
- R9: In watchdog mode, a terminal step sets `wdog_rst`, which stays high.
  - Writing 16'h5AC3 to address 0 is a service. It reloads the start value and clears `wdog_rst`.
  - A service leaves the control fields unchanged in every mode.
- R10: Any other write to address 0 loads new control fields, sets the count to the start value for the new direction, and clears `wave_out`, `wdog_rst` and the pulse-mode state.
- R11: After reset, the count, capture value, `tc_pulse`, `wave_out` and `wdog_rst` are all 0. The channel is stopped, in pulse mode, counting down, with reload 0.
- R12: A write to address 3 changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address |
| wr_data | input | 16 | Write data |
| gate_en | input | 1 | Counting enable level |
| trig_in | input | 1 | Asynchronous trigger, rising edge |
| evt_in | input | 1 | Asynchronous event, rising edge |
| count_value | output | 16 | Present count |
| cap_value | output | 16 | Captured count |
| tc_pulse | output | 1 | One-cycle terminal-count pulse |
| wave_out | output | 1 | Pulse or waveform output |
| wdog_rst | output | 1 | Watchdog reset request |

## Verification
The bench drives both divider clamp edges. A design that clamped wrongly would show a gap between terminal pulses other than 24 or 560 cycles.

It lowers the gate in the middle of a period, starts and restarts one-shots, and feeds event edges while the divider is ticking. A step lost or doubled here shows up as a count that drifts away from the reference model.

It services the watchdog after expiry and writes to the undecoded address while the channel is stopped. A design that decoded address 3 as control would start counting. A design that treated the service key as a control write would change mode.

// File: rtl/mmct_pkg.sv
package mmct_pkg;
  localparam logic [2:0] MD_PULSE   = 3'd0;
  localparam logic [2:0] MD_WAVE    = 3'd1;
  localparam logic [2:0] MD_EVENT   = 3'd2;
  localparam logic [2:0] MD_CAPTURE = 3'd3;
  localparam logic [2:0] MD_WDOG    = 3'd4;

  localparam logic [1:0] A_CTRL   = 2'd0;
  localparam logic [1:0] A_RELOAD = 2'd1;
  localparam logic [1:0] A_DIV    = 2'd2;

  typedef struct packed {
    logic       run;
    logic       up;
    logic [2:0] mode;
  } ctrl_t;

  function automatic logic mode_is_timed(input logic [2:0] m);
    return (m == MD_PULSE) || (m == MD_WAVE) || (m == MD_CAPTURE) || (m == MD_WDOG);
  endfunction
endpackage

// File: rtl/mmct_prescaler.sv
module mmct_prescaler #(
  parameter int PSC_W   = 9,
  parameter int PSC_MIN = 4,
  parameter int PSC_MAX = 280
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             clear,
  input  logic [PSC_W-1:0] ratio_raw,
  output logic             tick
);
  localparam logic [PSC_W-1:0] LO = PSC_W'(PSC_MIN);
  localparam logic [PSC_W-1:0] HI = PSC_W'(PSC_MAX);

  function automatic logic [PSC_W-1:0] clamp_ratio(input logic [PSC_W-1:0] raw);
    if (raw < LO) return LO;
    if (raw > HI) return HI;
    return raw;
  endfunction

  logic [PSC_W-1:0] div_cnt;
  logic [PSC_W-1:0] last_val;
  logic             at_last;

  assign last_val = clamp_ratio(ratio_raw) - PSC_W'(1);
  assign at_last  = (div_cnt >= last_val);
  assign tick     = run && at_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 div_cnt <= '0;
    else if (!run || clear)     div_cnt <= '0;
    else if (at_last)           div_cnt <= '0;
    else                        div_cnt <= div_cnt + PSC_W'(1);
  end
endmodule

// File: rtl/mmct_edge_sync.sv
module mmct_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise
);
  logic [STAGES:0] shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shreg <= '0;
    else        shreg <= {shreg[STAGES-1:0], din};
  end

  assign rise = shreg[STAGES-1] & ~shreg[STAGES];
endmodule

// File: rtl/mmct_core.sv
module mmct_core
  import mmct_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  ctrl_t            ctrl,
  input  logic [CNT_W-1:0] reload,
  input  logic             gate_en,
  input  logic             tick,
  input  logic             evt_rise,
  input  logic             trig_rise,
  input  logic             cfg_load,
  input  logic             cfg_up,
  input  logic             svc_reload,
  output logic [CNT_W-1:0] count_q,
  output logic [CNT_W-1:0] cap_q,
  output logic             tc_q,
  output logic             wave_q,
  output logic             wdog_q,
  output logic             step,
  output logic             restart,
  output logic             cap_load
);
  function automatic logic [CNT_W-1:0] start_of(input logic up, input logic [CNT_W-1:0] rl);
    return up ? '0 : rl;
  endfunction

  function automatic logic at_terminal(input logic [CNT_W-1:0] c, input logic [CNT_W-1:0] rl,
                                       input logic up);
    return up ? (c >= rl) : (c == '0);
  endfunction

  function automatic logic [CNT_W-1:0] step_of(input logic [CNT_W-1:0] c, input logic up);
    return up ? c + CNT_W'(1) : c - CNT_W'(1);
  endfunction

  logic             active_q;
  logic             src;
  logic             pulse_fire;
  logic             term;
  logic [CNT_W-1:0] start_val;

  assign start_val  = start_of(ctrl.up, reload);
  assign term       = at_terminal(count_q, reload, ctrl.up);
  assign src        = (ctrl.mode == MD_EVENT) ? evt_rise : (mode_is_timed(ctrl.mode) && tick);
  assign pulse_fire = ctrl.run && (ctrl.mode == MD_PULSE) && trig_rise;
  assign step       = ctrl.run && gate_en && src && ((ctrl.mode != MD_PULSE) || active_q);
  assign restart    = cfg_load || svc_reload || pulse_fire;
  assign cap_load   = !cfg_load && ctrl.run && (ctrl.mode == MD_CAPTURE) && trig_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q  <= '0;
      cap_q    <= '0;
      tc_q     <= 1'b0;
      wave_q   <= 1'b0;
      wdog_q   <= 1'b0;
      active_q <= 1'b0;
    end else begin
      tc_q <= 1'b0;
      if (cfg_load) begin
        count_q  <= start_of(cfg_up, reload);
        wave_q   <= 1'b0;
        wdog_q   <= 1'b0;
        active_q <= 1'b0;
      end else if (svc_reload) begin
        count_q <= start_val;
        wdog_q  <= 1'b0;
      end else if (pulse_fire) begin
        count_q  <= start_val;
        active_q <= 1'b1;
        wave_q   <= 1'b1;
      end else if (step) begin
        if (term) begin
          count_q <= start_val;
          tc_q    <= 1'b1;
          unique case (ctrl.mode)
            MD_WAVE:  wave_q <= ~wave_q;
            MD_PULSE: begin
              wave_q   <= 1'b0;
              active_q <= 1'b0;
            end
            MD_WDOG:  wdog_q <= 1'b1;
            default:  ;
          endcase
        end else begin
          count_q <= step_of(count_q, ctrl.up);
        end
      end
      if (cap_load) cap_q <= count_q;
    end
  end
endmodule

// File: rtl/mmct_channel.sv
module mmct_channel
  import mmct_pkg::*;
#(
  parameter int              CNT_W       = 16,
  parameter int              PSC_W       = 9,
  parameter int              PSC_MIN     = 4,
  parameter int              PSC_MAX     = 280,
  parameter int              SYNC_STAGES = 2,
  parameter logic [CNT_W-1:0] SERVICE_KEY = 16'h5AC3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             gate_en,
  input  logic             trig_in,
  input  logic             evt_in,
  output logic [CNT_W-1:0] count_value,
  output logic [CNT_W-1:0] cap_value,
  output logic             tc_pulse,
  output logic             wave_out,
  output logic             wdog_rst
);
  localparam int CTRL_W = $bits(ctrl_t);

  ctrl_t            ctrl_q;
  logic [CNT_W-1:0] reload_q;
  logic [PSC_W-1:0] div_q;

  logic is_key;
  logic cfg_load;
  logic svc_reload;
  logic tick_w;
  logic trig_rise_w;
  logic evt_rise_w;
  logic step_w;
  logic restart_w;
  logic cap_load_w;

  assign is_key     = (wr_data == SERVICE_KEY);
  assign cfg_load   = wr_en && (wr_addr == A_CTRL) && !is_key;
  assign svc_reload = wr_en && (wr_addr == A_CTRL) && is_key && (ctrl_q.mode == MD_WDOG);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      reload_q <= '0;
      div_q    <= '0;
    end else if (wr_en) begin
      if (cfg_load)                 ctrl_q   <= ctrl_t'(wr_data[CTRL_W-1:0]);
      if (wr_addr == A_RELOAD)      reload_q <= wr_data;
      if (wr_addr == A_DIV)         div_q    <= wr_data[PSC_W-1:0];
    end
  end

  mmct_prescaler #(.PSC_W(PSC_W), .PSC_MIN(PSC_MIN), .PSC_MAX(PSC_MAX)) u_div (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (ctrl_q.run),
    .clear     (cfg_load || svc_reload),
    .ratio_raw (div_q),
    .tick      (tick_w)
  );

  mmct_edge_sync #(.STAGES(SYNC_STAGES)) u_trig_sync (
    .clk(clk), .rst_n(rst_n), .din(trig_in), .rise(trig_rise_w)
  );

  mmct_edge_sync #(.STAGES(SYNC_STAGES)) u_evt_sync (
    .clk(clk), .rst_n(rst_n), .din(evt_in), .rise(evt_rise_w)
  );

  mmct_core #(.CNT_W(CNT_W)) u_core (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctrl       (ctrl_q),
    .reload     (reload_q),
    .gate_en    (gate_en),
    .tick       (tick_w),
    .evt_rise   (evt_rise_w),
    .trig_rise  (trig_rise_w),
    .cfg_load   (cfg_load),
    .cfg_up     (wr_data[3]),
    .svc_reload (svc_reload),
    .count_q    (count_value),
    .cap_q      (cap_value),
    .tc_q       (tc_pulse),
    .wave_q     (wave_out),
    .wdog_q     (wdog_rst),
    .step       (step_w),
    .restart    (restart_w),
    .cap_load   (cap_load_w)
  );
endmodule

// File: rtl/mmct_channel_checks.sv
module mmct_channel_checks #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             step,
  input logic             restart,
  input logic             cap_load,
  input logic             cfg_load,
  input logic             svc_reload,
  input logic             wave_mode,
  input logic             tc_pulse,
  input logic             wave_out,
  input logic             wdog_rst,
  input logic [CNT_W-1:0] count_value,
  input logic [CNT_W-1:0] cap_value
);
  p_tick_spacing_r1: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);

  p_tc_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tc_pulse |=> !tc_pulse);

  p_hold_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !restart) |=> $stable(count_value));

  p_wave_toggle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wave_mode && !cfg_load) |=> ((wave_out != $past(wave_out)) == tc_pulse));

  p_cap_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_load |=> $stable(cap_value));

  p_wdog_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wdog_rst && !cfg_load && !svc_reload) |=> wdog_rst);
endmodule

bind mmct_channel mmct_channel_checks #(.CNT_W(CNT_W)) u_checks (
  .clk         (clk),
  .rst_n       (rst_n),
  .tick        (tick_w),
  .step        (step_w),
  .restart     (restart_w),
  .cap_load    (cap_load_w),
  .cfg_load    (cfg_load),
  .svc_reload  (svc_reload),
  .wave_mode   (ctrl_q.mode == mmct_pkg::MD_WAVE),
  .tc_pulse    (tc_pulse),
  .wave_out    (wave_out),
  .wdog_rst    (wdog_rst),
  .count_value (count_value),
  .cap_value   (cap_value)
);

// File: tb/mmct_channel_tb.sv
module mmct_channel_tb;
  localparam int CLK_PERIOD = 10;
  localparam int KEY = 16'h5AC3;

  logic        clk = 0, rst_n = 0, wr_en = 0, gate_en = 1, trig_in = 0, evt_in = 0;
  logic [1:0]  wr_addr = 0;
  logic [15:0] wr_data = 0;
  logic [15:0] count_value, cap_value;
  logic        tc_pulse, wave_out, wdog_rst;

  int checks = 0, fails = 0, cyc = 0;
  bit compare_on = 0;
  string cur_req = "R11";

  mmct_channel u_dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  // reference model state
  int m_mode, m_up, m_run, m_reload, m_psc, m_cnt, m_cap, m_tc, m_wave, m_wd, m_act, m_pc;
  bit t1, t2, t3, e1, e2, e3;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 0; m_up = 0; m_run = 0; m_reload = 0; m_psc = 0;
      m_cnt = 0; m_cap = 0; m_tc = 0; m_wave = 0; m_wd = 0; m_act = 0; m_pc = 0;
      {t1, t2, t3, e1, e2, e3} = '0;
    end else begin
      int r, start, nxt_cnt, nxt_pc;
      bit tick, trise, erise, wrc, svc, src, stp, term, fire, capt;
      r     = (m_psc < 4) ? 4 : (m_psc > 280 ? 280 : m_psc);
      tick  = m_run && (m_pc >= r - 1);
      trise = t2 && !t3;
      erise = e2 && !e3;
      wrc   = wr_en && wr_addr == 0 && wr_data != KEY;
      svc   = wr_en && wr_addr == 0 && wr_data == KEY && m_mode == 4;
      nxt_pc = (!m_run || wrc || svc || m_pc >= r - 1) ? 0 : m_pc + 1;
      start = m_up ? 0 : m_reload;
      term  = m_up ? (m_cnt >= m_reload) : (m_cnt == 0);
      src   = (m_mode == 2) ? erise : ((m_mode <= 4) ? tick : 0);
      stp   = m_run && gate_en && src && (m_mode != 0 || m_act);
      fire  = m_run && m_mode == 0 && trise;
      capt  = !wrc && m_run && m_mode == 3 && trise;
      if (capt) m_cap = m_cnt;
      m_tc = 0;
      if (wrc) begin
        m_cnt = wr_data[3] ? 0 : m_reload; m_wave = 0; m_wd = 0; m_act = 0;
      end else if (svc) begin
        m_cnt = start; m_wd = 0;
      end else if (fire) begin
        m_cnt = start; m_act = 1; m_wave = 1;
      end else if (stp) begin
        if (term) begin
          m_cnt = start; m_tc = 1;
          if (m_mode == 1) m_wave = !m_wave;
          if (m_mode == 0) begin m_wave = 0; m_act = 0; end
          if (m_mode == 4) m_wd = 1;
        end else begin
          nxt_cnt = m_up ? m_cnt + 1 : m_cnt - 1;
          m_cnt = nxt_cnt & 16'hFFFF;
        end
      end
      m_pc = nxt_pc;
      if (wrc) begin
        m_mode = wr_data[2:0]; m_up = wr_data[3]; m_run = wr_data[4];
      end
      if (wr_en && wr_addr == 1) m_reload = wr_data;
      if (wr_en && wr_addr == 2) m_psc = wr_data[8:0];
      t3 = t2; t2 = t1; t1 = trig_in;
      e3 = e2; e2 = e1; e1 = evt_in;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d (t=%0t)", req, what, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (rst_n && compare_on) begin
      chk({cur_req, "/R2"}, "count_value", count_value, m_cnt);
      chk({cur_req, "/R3"}, "tc_pulse", tc_pulse, m_tc);
      chk({cur_req, "/R5"}, "wave_out", wave_out, m_wave);
      chk({cur_req, "/R8"}, "cap_value", cap_value, m_cap);
      chk({cur_req, "/R9"}, "wdog_rst", wdog_rst, m_wd);
    end
  end

  task automatic report();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d expected <150000 cycles", cyc);
      report();
    end
  end

  task automatic wr(input logic [1:0] a, input int d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d[15:0];
    @(negedge clk); wr_en = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_pin(input bit is_trig);
    @(negedge clk);
    if (is_trig) trig_in = 1; else evt_in = 1;
    idle(3);
    if (is_trig) trig_in = 0; else evt_in = 0;
    idle(3);
  endtask

  task automatic tc_gap(output int gap);
    while (tc_pulse !== 1'b1) @(negedge clk);
    gap = 0;
    do begin @(negedge clk); gap++; end while (tc_pulse !== 1'b1);
  endtask

  initial begin
    int g, snap;
    idle(3);
    rst_n = 1;
    @(negedge clk);
    // R11: reset state
    chk("R11", "count_value", count_value, 0);
    chk("R11", "cap_value", cap_value, 0);
    chk("R11", "tc|wave|wdog", {tc_pulse, wave_out, wdog_rst}, 0);
    compare_on = 1;

    // R1 + R5: divider below range clamps to 4, down waveform, reload 5
    cur_req = "R5";
    wr(2, 0); wr(1, 5); wr(0, 5'b1_0_001);
    tc_gap(g); chk("R1", "tc gap at ratio 4", g, 24);
    idle(60);

    // R1: divider above range clamps to 280, up, reload 1
    cur_req = "R1";
    wr(2, 300); wr(1, 1); wr(0, 5'b1_1_001);
    tc_gap(g); chk("R1", "tc gap at ratio 280", g, 560);

    // R4: gate low holds the count
    cur_req = "R4";
    wr(2, 7); wr(1, 30); wr(0, 5'b1_1_001);
    idle(40);
    gate_en = 0; @(negedge clk); snap = count_value;
    idle(30); chk("R4", "count held by gate", count_value, snap);
    gate_en = 1; idle(40);

    // R10: control write mid-count restarts
    cur_req = "R10";
    wr(0, 5'b1_1_001);
    chk("R10", "count after ctrl write", count_value, 0);
    chk("R10", "wave after ctrl write", wave_out, 0);
    idle(20);

    // R6: pulse mode one-shot
    cur_req = "R6";
    wr(2, 4); wr(1, 4); wr(0, 5'b1_0_000);
    idle(12); chk("R6", "idle count held", count_value, 4);
    pulse_pin(1);
    chk("R6", "wave high after trigger", wave_out, 1);
    idle(30); chk("R6", "wave low after period", wave_out, 0);
    pulse_pin(1); idle(8); pulse_pin(1); idle(30);

    // R7: event counting, divider ignored
    cur_req = "R7";
    wr(2, 4); wr(1, 2); wr(0, 5'b1_1_010);
    idle(20); chk("R7", "no steps without events", count_value, 0);
    pulse_pin(0); pulse_pin(0);
    chk("R7", "two events", count_value, 2);
    pulse_pin(0); chk("R7", "wrap after third event", count_value, 0);
    gate_en = 0; pulse_pin(0); chk("R7", "gated event ignored", count_value, 0);
    gate_en = 1;

    // R8: capture mode
    cur_req = "R8";
    wr(1, 100); wr(0, 5'b1_0_011);
    idle(50); pulse_pin(1);
    snap = cap_value;
    chk("R8", "capture taken", (snap != 0 && snap < 100) ? 1 : 0, 1);
    idle(30); chk("R8", "counter kept running", (count_value != snap) ? 1 : 0, 1);

    // R9: watchdog expiry, service, config retained
    cur_req = "R9";
    wr(1, 3); wr(0, 5'b1_0_100);
    idle(40); chk("R9", "wdog asserted", wdog_rst, 1);
    wr(0, KEY);
    chk("R9", "wdog cleared by service", wdog_rst, 0);
    chk("R9", "count reloaded by service", count_value, 3);
    idle(40); chk("R9", "watchdog mode kept", wdog_rst, 1);

    // R12: address 3 is not decoded
    cur_req = "R12";
    wr(0, 5'b0_1_001);
    wr(3, 16'h0019);
    idle(30); chk("R12", "count after addr3 write", count_value, 0);
    chk("R12", "wave after addr3 write", wave_out, 0);

    idle(5);
    report();
  end
endmodule